// File: doc/BRIEF.md
# Boolean Bit Processor

This block carries out the single-bit instructions of a small controller. The carry flag works as a one-bit accumulator. A direct bit, or its complement, can be ANDed or ORed into carry. A bit can be copied into carry, and carry can be copied into a bit. Carry, or any direct bit, can be set, cleared or inverted. The block turns the 8-bit bit address into a byte address and a bit index. It drives that byte address to an external byte store and receives the byte back in the same cycle. Writes to a bit go back to the store as a whole byte.

The status-word byte holds the flags. The carry is bit 7 of that byte. The live carry value comes in and goes out on dedicated ports, and the block keeps the byte image of the status word consistent with it. Each accepted operation produces its registered result one clock later.

Top module: `bbp_core`

## Requirements
- R1: While reset is held, and after it is released, `res_vld_o`, `cy_we_o` and `mem_we_o` are 0 until an operation is accepted.
- R2: A bit address below 128 selects byte 32 + addr/8, with bit index addr mod 8. This holds on `rd_addr_o`, which responds combinationally, and on `mem_waddr_o`.
- R3: A bit address of 128 or above selects the byte whose address is the bit address with its low 3 bits cleared. The bit index is the low 3 bits.
- R4: Op code 1 sets carry to carry AND bit. Op code 2 sets carry to carry AND NOT bit. Both assert `cy_we_o` and leave `mem_we_o` low, so the stored bit is unchanged.
- R5: Op code 3 sets carry to carry OR bit. Op code 4 sets carry to carry OR NOT bit. Both write only carry.
- R6: Op code 5 copies the addressed bit into carry. Op code 6 writes carry into the addressed bit.
- R7: Op code 7 sets carry to 1, op code 8 clears it, and op code 9 inverts it. None of these writes memory.
- R8: Op code 10 sets the addressed bit, op code 11 clears it, and op code 12 inverts it. Each is done as a byte write in which the other 7 bits keep their read values.
- R9: Bit address 215 is the carry bit (bit 7 of byte 208). Reading it returns `cy_i`, whatever the stored byte holds. Writing it asserts `cy_we_o` with the written value as the new carry.
- R10: Every byte write to address 208 carries the resulting carry in bit 7. Writes to the other bits of the status word (addresses 208 to 214) do not change carry.
- R11: Results appear one clock after `op_vld_i` is sampled high, with `res_vld_o` high. Op code 0 and op codes 13 to 15 produce no write enables. A cycle without `op_vld_i` produces no result and no write enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_vld_i | input | 1 | Operation present this cycle |
| op_code_i | input | 4 | Operation code |
| bit_addr_i | input | 8 | Direct bit address |
| cy_i | input | 1 | Current carry flag |
| rd_addr_o | output | 8 | Byte address of the addressed bit (combinational) |
| rd_data_i | input | 8 | Byte read from `rd_addr_o` in the same cycle |
| res_vld_o | output | 1 | Result valid |
| cy_o | output | 1 | Resulting carry |
| cy_we_o | output | 1 | Carry write enable |
| mem_we_o | output | 1 | Byte write enable |
| mem_waddr_o | output | 8 | Byte write address |
| mem_wdata_o | output | 8 | Byte write data |

## Verification
The AND and OR forms run through all four combinations of carry and bit, in both the true and the complemented form. These sweeps separate a missing inversion, a swapped operator and a write that leaks into memory. Bit writes are made into bytes that hold alternating patterns such as 0xA5, so any disturbed neighbour bit shows up. Addresses at the edges of the low range and inside the high range catch mapping errors. Operations on address 215 and on the other status-word bits separate a correct carry alias from a plain memory write.

// File: rtl/bbp_pkg.sv
package bbp_pkg;
    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_ANDC  = 4'd1,
        OP_ANDNC = 4'd2,
        OP_ORC   = 4'd3,
        OP_ORNC  = 4'd4,
        OP_LDC   = 4'd5,
        OP_STC   = 4'd6,
        OP_SETC  = 4'd7,
        OP_CLRC  = 4'd8,
        OP_CPLC  = 4'd9,
        OP_SETB  = 4'd10,
        OP_CLRB  = 4'd11,
        OP_CPLB  = 4'd12
    } bop_e;
endpackage

// File: rtl/bbp_addr_map.sv
module bbp_addr_map #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned RAM_BASE = 32,
    parameter int unsigned PSW_BYTE = 208,
    parameter int unsigned CY_IDX   = 7
) (
    input  logic [ADDR_W-1:0]         bit_addr,
    output logic [ADDR_W-1:0]         byte_addr,
    output logic [$clog2(DATA_W)-1:0] bit_idx,
    output logic                      is_psw,
    output logic                      is_cy
);
    localparam int unsigned IDX_W = $clog2(DATA_W);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(RAM_BASE);
    localparam logic [ADDR_W-1:0] PSW_A  = ADDR_W'(PSW_BYTE);
    localparam logic [IDX_W-1:0]  CY_I   = IDX_W'(CY_IDX);

    always_comb begin
        bit_idx = bit_addr[IDX_W-1:0];
        if (bit_addr[ADDR_W-1]) begin
            byte_addr = {bit_addr[ADDR_W-1:IDX_W], {IDX_W{1'b0}}};
        end else begin
            byte_addr = BASE_A + (bit_addr >> IDX_W);
        end
        is_psw = (byte_addr == PSW_A);
        is_cy  = is_psw && (bit_idx == CY_I);
    end
endmodule

// File: rtl/bbp_alu.sv
module bbp_alu
    import bbp_pkg::*;
(
    input  logic [3:0] op,
    input  logic       bit_i,
    input  logic       cy_i,
    output logic       cy_o,
    output logic       cy_we_o,
    output logic       bit_o,
    output logic       bit_we_o
);
    always_comb begin
        cy_o     = cy_i;
        cy_we_o  = 1'b0;
        bit_o    = bit_i;
        bit_we_o = 1'b0;
        case (op)
            OP_ANDC:  begin cy_o = cy_i & bit_i;  cy_we_o = 1'b1; end
            OP_ANDNC: begin cy_o = cy_i & ~bit_i; cy_we_o = 1'b1; end
            OP_ORC:   begin cy_o = cy_i | bit_i;  cy_we_o = 1'b1; end
            OP_ORNC:  begin cy_o = cy_i | ~bit_i; cy_we_o = 1'b1; end
            OP_LDC:   begin cy_o = bit_i;         cy_we_o = 1'b1; end
            OP_STC:   begin bit_o = cy_i;         bit_we_o = 1'b1; end
            OP_SETC:  begin cy_o = 1'b1;          cy_we_o = 1'b1; end
            OP_CLRC:  begin cy_o = 1'b0;          cy_we_o = 1'b1; end
            OP_CPLC:  begin cy_o = ~cy_i;         cy_we_o = 1'b1; end
            OP_SETB:  begin bit_o = 1'b1;         bit_we_o = 1'b1; end
            OP_CLRB:  begin bit_o = 1'b0;         bit_we_o = 1'b1; end
            OP_CPLB:  begin bit_o = ~bit_i;       bit_we_o = 1'b1; end
            default:  ;
        endcase
    end
endmodule

// File: rtl/bbp_core.sv
module bbp_core
    import bbp_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned RAM_BASE = 32,
    parameter int unsigned PSW_BYTE = 208,
    parameter int unsigned CY_IDX   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_vld_i,
    input  logic [3:0]        op_code_i,
    input  logic [ADDR_W-1:0] bit_addr_i,
    input  logic              cy_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              res_vld_o,
    output logic              cy_o,
    output logic              cy_we_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_waddr_o,
    output logic [DATA_W-1:0] mem_wdata_o
);
    localparam int unsigned IDX_W    = $clog2(DATA_W);
    localparam int unsigned LO_BYTES = 2 ** (ADDR_W - 1 - IDX_W);
    localparam logic [ADDR_W-1:0] LO_FIRST = ADDR_W'(RAM_BASE);
    localparam logic [ADDR_W-1:0] LO_LAST  = ADDR_W'(RAM_BASE + LO_BYTES - 1);
    localparam logic [ADDR_W-1:0] PSW_A    = ADDR_W'(PSW_BYTE);
    localparam logic [ADDR_W-1:0] CY_BIT_A = ADDR_W'(PSW_BYTE + CY_IDX);

    typedef struct packed {
        logic              vld;
        logic              cy;
        logic              cy_we;
        logic              we;
        logic [ADDR_W-1:0] waddr;
        logic [DATA_W-1:0] wdata;
    } state_t;

    state_t st_d, st_q;

    logic [ADDR_W-1:0] map_byte;
    logic [IDX_W-1:0]  map_idx;
    logic              map_psw, map_cy;
    logic              src_bit;
    logic              alu_cy, alu_cy_we, alu_bit, alu_bit_we;

    bbp_addr_map #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAM_BASE(RAM_BASE),
        .PSW_BYTE(PSW_BYTE), .CY_IDX(CY_IDX)
    ) u_map (
        .bit_addr (bit_addr_i),
        .byte_addr(map_byte),
        .bit_idx  (map_idx),
        .is_psw   (map_psw),
        .is_cy    (map_cy)
    );

    assign rd_addr_o = map_byte;
    // the live carry overrides the stored image of the carry bit
    assign src_bit   = map_cy ? cy_i : rd_data_i[map_idx];

    bbp_alu u_alu (
        .op      (op_code_i),
        .bit_i   (src_bit),
        .cy_i    (cy_i),
        .cy_o    (alu_cy),
        .cy_we_o (alu_cy_we),
        .bit_o   (alu_bit),
        .bit_we_o(alu_bit_we)
    );

    always_comb begin
        logic              new_cy;
        logic [DATA_W-1:0] img;
        new_cy = (alu_bit_we && map_cy) ? alu_bit : alu_cy;
        img    = rd_data_i;
        img[map_idx] = alu_bit;
        if (map_psw) begin
            img[CY_IDX] = new_cy;
        end
        st_d     = st_q;
        st_d.vld = op_vld_i;
        if (op_vld_i) begin
            st_d.cy    = new_cy;
            st_d.cy_we = alu_cy_we | (alu_bit_we & map_cy);
            st_d.we    = alu_bit_we;
            st_d.waddr = map_byte;
            st_d.wdata = img;
        end else begin
            st_d.cy_we = 1'b0;
            st_d.we    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_vld_o   = st_q.vld;
    assign cy_o        = st_q.cy;
    assign cy_we_o     = st_q.cy_we;
    assign mem_we_o    = st_q.we;
    assign mem_waddr_o = st_q.waddr;
    assign mem_wdata_o = st_q.wdata;

    p_lo_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o && !mem_waddr_o[ADDR_W-1] |->
            (mem_waddr_o >= LO_FIRST) && (mem_waddr_o <= LO_LAST));

    p_hi_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o && mem_waddr_o[ADDR_W-1] |-> mem_waddr_o[IDX_W-1:0] == '0);

    p_cy_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        op_vld_i && (op_code_i inside {OP_ANDC, OP_ANDNC, OP_ORC, OP_ORNC,
                                       OP_LDC, OP_SETC, OP_CLRC, OP_CPLC})
        |=> cy_we_o && !mem_we_o);

    p_cy_alias_r9: assert property (@(posedge clk) disable iff (!rst_n)
        op_vld_i && op_code_i == OP_SETB && bit_addr_i == CY_BIT_A
        |=> cy_we_o && cy_o && mem_we_o);

    p_psw_carry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o && mem_waddr_o == PSW_A |-> mem_wdata_o[CY_IDX] == cy_o);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !op_vld_i |=> !res_vld_o && !cy_we_o && !mem_we_o);
endmodule

// File: tb/sim_bbp_core.sv
`timescale 1ns/1ps
module sim_bbp_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_vld = 1'b0;
    logic [3:0] op_code = 4'd0;
    logic [7:0] bit_addr = 8'd0;
    logic       cy = 1'b0;
    logic [7:0] rd_addr, rd_data;
    logic       res_vld, cy_o, cy_we, mem_we;
    logic [7:0] waddr, wdata;
    logic [7:0] mem [256];

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    assign rd_data = mem[rd_addr];

    bbp_core u0 (
        .clk(clk), .rst_n(rst_n), .op_vld_i(op_vld), .op_code_i(op_code),
        .bit_addr_i(bit_addr), .cy_i(cy), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
        .res_vld_o(res_vld), .cy_o(cy_o), .cy_we_o(cy_we), .mem_we_o(mem_we),
        .mem_waddr_o(waddr), .mem_wdata_o(wdata)
    );

    function automatic logic [7:0] exp_byte(input logic [7:0] a);
        return a[7] ? {a[7:3], 3'b000} : 8'd32 + {3'b000, a[7:3]};
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic run(input logic [3:0] op, input logic [7:0] a, input logic c);
        @(negedge clk);
        op_vld = 1'b1; op_code = op; bit_addr = a; cy = c;
        @(negedge clk);
        op_vld = 1'b0;
        if (mem_we) mem[waddr] = wdata;
    endtask

    task automatic t_reset_r1();
        chk("R1 res_vld", res_vld, 0);
        chk("R1 cy_we", cy_we, 0);
        chk("R1 mem_we", mem_we, 0);
    endtask

    task automatic t_map_r2_r3();
        logic [7:0] probe [5] = '{8'h00, 8'h7F, 8'h15, 8'h93, 8'hFF};
        foreach (probe[i]) begin
            @(negedge clk);
            bit_addr = probe[i];
            #1;
            chk(probe[i][7] ? "R3 rd_addr" : "R2 rd_addr", rd_addr, exp_byte(probe[i]));
        end
        chk("R2 map 0", exp_byte(8'h00), 32);
        chk("R2 map 127", exp_byte(8'h7F), 47);
        mem[34] = 8'h00;
        run(4'd10, 8'h15, 1'b0);
        chk("R2 waddr", waddr, 34);
        chk("R2 wdata", wdata, 8'h20);
        mem[8'h90] = 8'h00;
        run(4'd10, 8'h93, 1'b0);
        chk("R3 waddr", waddr, 8'h90);
        chk("R3 wdata", wdata, 8'h08);
    endtask

    task automatic t_and_or_r4_r5();
        for (int c = 0; c < 2; c++) begin
            for (int b = 0; b < 2; b++) begin
                mem[33] = b[0] ? 8'h08 : 8'hF7;
                run(4'd1, 8'h0B, c[0]);
                chk("R4 and cy", cy_o, c & b);
                chk("R4 and mem_we", mem_we, 0);
                run(4'd2, 8'h0B, c[0]);
                chk("R4 andn cy", cy_o, c & (1 - b));
                chk("R4 andn cy_we", cy_we, 1);
                chk("R4 andn mem_we", mem_we, 0);
                run(4'd3, 8'h0B, c[0]);
                chk("R5 or cy", cy_o, c | b);
                run(4'd4, 8'h0B, c[0]);
                chk("R5 orn cy", cy_o, c | (1 - b));
                chk("R5 orn mem_we", mem_we, 0);
                chk("R5 bit kept", mem[33], b[0] ? 8'h08 : 8'hF7);
            end
        end
    endtask

    task automatic t_move_r6();
        mem[8'hE0] = 8'h00;
        run(4'd6, 8'hE4, 1'b1);
        chk("R6 st we", mem_we, 1);
        chk("R6 st data", wdata, 8'h10);
        run(4'd5, 8'hE4, 1'b0);
        chk("R6 ld cy", cy_o, 1);
        run(4'd6, 8'hE4, 1'b0);
        chk("R6 st clr", wdata, 8'h00);
        run(4'd5, 8'hE4, 1'b1);
        chk("R6 ld cy0", cy_o, 0);
    endtask

    task automatic t_carry_r7();
        run(4'd7, 8'h00, 1'b0);
        chk("R7 set", {cy_we, cy_o, mem_we}, 3'b110);
        run(4'd8, 8'h00, 1'b1);
        chk("R7 clr", {cy_we, cy_o, mem_we}, 3'b100);
        run(4'd9, 8'h00, 1'b1);
        chk("R7 cpl1", cy_o, 0);
        run(4'd9, 8'h00, 1'b0);
        chk("R7 cpl0", cy_o, 1);
    endtask

    task automatic t_bits_r8();
        mem[37] = 8'hA5;
        run(4'd10, 8'd41, 1'b0);
        chk("R8 setb", wdata, 8'hA7);
        run(4'd11, 8'd40, 1'b0);
        chk("R8 clrb", wdata, 8'hA6);
        run(4'd12, 8'd47, 1'b0);
        chk("R8 cplb", wdata, 8'h26);
        chk("R8 cy_we", cy_we, 0);
        chk("R8 mem", mem[37], 8'h26);
    endtask

    task automatic t_alias_r9_r10();
        mem[208] = 8'h00;
        run(4'd5, 8'd215, 1'b1);
        chk("R9 ld live cy", cy_o, 1);
        run(4'd10, 8'd215, 1'b0);
        chk("R9 setb cy", {cy_we, cy_o}, 2'b11);
        chk("R9 setb data", wdata, 8'h80);
        run(4'd11, 8'd215, 1'b1);
        chk("R9 clrb cy", {cy_we, cy_o}, 2'b10);
        mem[208] = 8'h00;
        run(4'd10, 8'd209, 1'b1);
        chk("R10 data", wdata, 8'h82);
        chk("R10 cy_we", cy_we, 0);
        chk("R10 cy", cy_o, 1);
    endtask

    task automatic t_nop_r11();
        run(4'd0, 8'h20, 1'b1);
        chk("R11 nop", {res_vld, cy_we, mem_we}, 3'b100);
        run(4'd15, 8'h20, 1'b1);
        chk("R11 op15", {res_vld, cy_we, mem_we}, 3'b100);
        run(4'd13, 8'h20, 1'b1);
        chk("R11 op13", {res_vld, cy_we, mem_we}, 3'b100);
        @(negedge clk);
        chk("R11 idle", {res_vld, cy_we, mem_we}, 3'b000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37);
        repeat (3) @(negedge clk);
        t_reset_r1();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_r1();
        t_map_r2_r3();
        t_and_or_r4_r5();
        t_move_r6();
        t_carry_r7();
        t_bits_r8();
        t_alias_r9_r10();
        t_nop_r11();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule